// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns bytes into asynchronous serial frames on one transmit line. A byte arrives through a valid/ready port and sits in a one-entry holding register. It waits there until the shifter is idle, transmission is enabled and an oversampling tick arrives. The shifter then sends a start bit, five to eight data bits with the least significant bit first, an optional parity bit and one or two stop bits. Each bit lasts a fixed number of oversampling ticks, 16 by default.

An 8-bit line-control input sets the shape of each frame: word length, parity mode (off, odd, even, or a constant sticky value) and stop-bit count. The shifter copies these settings when a frame starts, so changing the input during a frame does not affect that frame. A break request drives the line low at once and abandons any frame in progress. When the break is released, the line stays high for one full bit time before the next frame can start. Two status outputs are provided: `busy_o` shows that the line is in use, and `empty_o` shows that the holding register can take a byte.

Top module: `uart_frame_tx`

## Requirements
- R1: A frame is a 0 start bit followed by N data bits, least significant bit first. N is 5, 6, 7 or 8 for a word-length code of 0, 1, 2 or 3 in `lcr_i[6:5]`.
- R2: Every frame bit, including start and stop bits, stays on `tx_o` for exactly OSR ticks of `tick_i` (OSR = 16).
- R3: When `lcr_i[1]` is 1 and `lcr_i[7]` is 0, a parity bit follows the data bits. If `lcr_i[2]` is 1, the count of 1s over the data bits and the parity bit is even. If `lcr_i[2]` is 0, that count is odd.
- R4: When `lcr_i[1]` and `lcr_i[7]` are both 1, the parity bit is a constant: 0 when `lcr_i[2]` is 1, and 1 when `lcr_i[2]` is 0.
- R5: The frame ends with one stop bit (value 1), or with two stop bits when `lcr_i[3]` is 1.
- R6: After reset, `tx_o` is 1 and `busy_o` is 0. `busy_o` is 1 from the start bit to the end of the last stop bit. Whenever `busy_o` is 0, `tx_o` is 1.
- R7: `ready_o` equals `empty_o`. An accepted byte (`valid_i` and `ready_o` both 1 at a clock edge) makes `empty_o` 0 from the next cycle. `empty_o` returns to 1 in the cycle the byte's frame starts.
- R8: A frame starts only at a clock edge where `tick_i`, `en_i` and `tx_en_i` are all 1. Until then, a held byte waits, `tx_o` stays 1 and `busy_o` stays 0.
- R9: The frame settings are captured when the start bit begins. Changes to `lcr_i[7:1]` during a frame do not alter that frame.
- R10: While `lcr_i[0]` (break) is 1, `tx_o` is 0 from the next cycle and `busy_o` is 1. Any frame in progress is dropped, and a held byte stays held. After break clears, `tx_o` is 1 for OSR ticks. A pending frame then starts on the following tick.
- R11: `lcr_i[4]` has no effect on the frames produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling tick, one cycle wide |
| en_i | input | 1 | Global enable |
| tx_en_i | input | 1 | Transmit enable |
| lcr_i | input | 8 | Line control: [0] break, [1] parity on, [2] even select, [3] two stop, [4] ignored, [6:5] word length, [7] sticky parity |
| data_i | input | 8 | Byte to send |
| valid_i | input | 1 | `data_i` is valid |
| ready_o | output | 1 | Holding register can accept a byte |
| tx_o | output | 1 | Serial line, idle high |
| busy_o | output | 1 | Frame, break or post-break guard in progress |
| empty_o | output | 1 | Holding register empty |

## Verification
The bench decodes every frame at the middle and at the last tick of each bit. A bit that is one tick short shows up as a mismatch on its final sample. A bit that is one tick long leaves `busy_o` high one cycle past the expected end of the frame. Word lengths 5 and 8, both parity polarities, both sticky values and two stop bits are each run, so a mask error, a swapped parity sense or an inverted sticky value produces a wrong bit.

One test changes the line control in the middle of a frame. A design that reads the settings live instead of the captured copy would change the length or parity of that frame. Other tests hold a byte while either enable is low, and pull a break in the middle of a frame. The bench counts exactly 17 ticks from break release to the next start bit: 16 ticks of guard plus one tick to start. A design without the guard, or one that resumed the abandoned frame, misses that count.

// File: rtl/uft_pkg.sv
package uft_pkg;
  localparam int WORD_W = 8;

  typedef struct packed {
    logic       sticky;
    logic [1:0] wlen;
    logic       fifo_en;
    logic       two_stop;
    logic       even;
    logic       par_en;
    logic       brk;
  } lcr_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_MARK
  } tx_st_e;

  function automatic logic [WORD_W-1:0] word_mask(input logic [1:0] wlen);
    return {WORD_W{1'b1}} >> (2'd3 - wlen);
  endfunction

  function automatic logic par_bit(input lcr_t c, input logic [WORD_W-1:0] d);
    logic [WORD_W-1:0] m;
    m = d & word_mask(c.wlen);
    if (c.sticky) return ~c.even;
    return c.even ? ^m : ~^m;
  endfunction
endpackage

// File: rtl/uft_hold.sv
module uft_hold #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  input  logic         take_i,
  output logic         ready_o,
  output logic         full_o,
  output logic [W-1:0] data_o
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign ready_o = !full_q;
  assign full_o  = full_q;
  assign data_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (take_i) begin
      full_q <= 1'b0;
    end else if (valid_i && !full_q) begin
      full_q <= 1'b1;
      data_q <= data_i;
    end
  end
endmodule

// File: rtl/uft_tick_ctr.sv
module uft_tick_ctr #(
  parameter int OSR = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic done_o
);
  localparam int CNT_W = (OSR > 2) ? $clog2(OSR) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  generate
    if ((OSR & (OSR - 1)) == 0) begin : g_pow2
      assign cnt_inc = cnt_q + 1'b1;  // wraps naturally
    end else begin : g_any
      assign cnt_inc = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_inc;
  end

  assign done_o = tick_i && !clr_i && (cnt_q == LAST);
endmodule

// File: rtl/uft_framer.sv
module uft_framer
  import uft_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              go_i,
  input  lcr_t              cfg_i,
  input  logic              hold_full_i,
  input  logic [WORD_W-1:0] hold_data_i,
  input  logic              bit_done_i,
  output logic              take_o,
  output logic              clr_o,
  output logic              tx_o,
  output logic              busy_o
);
  tx_st_e            st_q;
  logic [WORD_W-1:0] sh_q;
  logic [2:0]        idx_q, last_q;
  logic              par_q, par_en_q, two_stop_q, stop2_q, brk_q;

  assign take_o = (st_q == S_IDLE) && !cfg_i.brk && go_i && tick_i && hold_full_i;
  assign clr_o  = take_o || cfg_i.brk;
  assign busy_o = (st_q != S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      sh_q       <= '0;
      idx_q      <= '0;
      last_q     <= '0;
      par_q      <= 1'b0;
      par_en_q   <= 1'b0;
      two_stop_q <= 1'b0;
      stop2_q    <= 1'b0;
      brk_q      <= 1'b0;
    end else begin
      brk_q <= cfg_i.brk;
      if (cfg_i.brk) begin
        st_q <= S_MARK;  // drop frame, hold line low
      end else begin
        unique case (st_q)
          S_IDLE: if (take_o) begin
            st_q       <= S_START;
            sh_q       <= hold_data_i;
            last_q     <= 3'd4 + {1'b0, cfg_i.wlen};
            par_q      <= par_bit(cfg_i, hold_data_i);
            par_en_q   <= cfg_i.par_en;
            two_stop_q <= cfg_i.two_stop;
          end
          S_START: if (bit_done_i) begin
            st_q  <= S_DATA;
            idx_q <= '0;
          end
          S_DATA: if (bit_done_i) begin
            sh_q <= sh_q >> 1;
            if (idx_q == last_q) begin
              st_q    <= par_en_q ? S_PAR : S_STOP;
              stop2_q <= 1'b0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          S_PAR: if (bit_done_i) begin
            st_q    <= S_STOP;
            stop2_q <= 1'b0;
          end
          S_STOP: if (bit_done_i) begin
            if (two_stop_q && !stop2_q) stop2_q <= 1'b1;
            else                        st_q    <= S_IDLE;
          end
          S_MARK: if (bit_done_i) st_q <= S_IDLE;  // guard bit after break
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (st_q)
      S_START: tx_o = 1'b0;
      S_DATA:  tx_o = sh_q[0];
      S_PAR:   tx_o = par_q;
      S_MARK:  tx_o = !brk_q;
      default: tx_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uft_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              tx_en_i,
  input  logic [7:0]        lcr_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              tx_o,
  output logic              busy_o,
  output logic              empty_o
);
  lcr_t              cfg;
  logic              take, clr, bit_done, hold_full;
  logic [WORD_W-1:0] hold_data;

  // queue-enable bit has no meaning without a queue
  assign cfg     = lcr_t'(lcr_i & 8'hEF);
  assign empty_o = !hold_full;

  uft_hold #(.W(WORD_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .data_i  (data_i),
    .take_i  (take),
    .ready_o (ready_o),
    .full_o  (hold_full),
    .data_o  (hold_data)
  );

  uft_tick_ctr #(.OSR(OSR)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clr_i  (clr),
    .done_o (bit_done)
  );

  uft_framer u_framer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .go_i        (en_i && tx_en_i),
    .cfg_i       (cfg),
    .hold_full_i (hold_full),
    .hold_data_i (hold_data),
    .bit_done_i  (bit_done),
    .take_o      (take),
    .clr_o       (clr),
    .tx_o        (tx_o),
    .busy_o      (busy_o)
  );
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic go_i,
  input logic brk_i,
  input logic valid_i,
  input logic ready_o,
  input logic tx_o,
  input logic busy_o,
  input logic empty_o
);
  assert_break_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |=> !tx_o);

  assert_idle_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o);

  assert_start_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) && !$past(brk_i) |-> $past(go_i) && $past(tick_i));

  assert_tick_aligned_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tx_o) |-> $past(tick_i) || $past(brk_i) || $past(brk_i, 2));

  assert_accept_fills_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> !empty_o && !ready_o);
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .go_i    (en_i && tx_en_i),
  .brk_i   (lcr_i[0]),
  .valid_i (valid_i),
  .ready_o (ready_o),
  .tx_o    (tx_o),
  .busy_o  (busy_o),
  .empty_o (empty_o)
);

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0] d;
    logic [7:0] l;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick;
  logic       en = 1'b1, tx_en = 1'b1, valid = 1'b0;
  logic [7:0] lcr = 8'h60, data = 8'h00;
  logic       ready, tx, busy, empty;
  logic [1:0] tdiv;
  logic       mon_on = 1'b0;
  int         checks = 0, errors = 0;
  item_t      q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) tdiv <= 2'd0;
    else        tdiv <= (tdiv == 2'd2) ? 2'd0 : tdiv + 2'd1;
  assign tick = (tdiv == 2'd2);

  uart_frame_tx u_uart_frame_tx (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .en_i(en), .tx_en_i(tx_en),
    .lcr_i(lcr), .data_i(data), .valid_i(valid), .ready_o(ready),
    .tx_o(tx), .busy_o(busy), .empty_o(empty)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    int c = 0;
    while (c < n) begin
      @(negedge clk);
      if (tick) c++;
    end
  endtask

  task automatic send(input logic [7:0] d, input bit push);
    @(negedge clk);
    while (!ready) @(negedge clk);
    valid = 1'b1;
    data  = d;
    if (push) q.push_back('{d: d, l: lcr});
    @(negedge clk);
    valid = 1'b0;
    chk(!empty && !ready, "R7", "holding register filled", empty, 0);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(q.size() == 0 && !busy && empty)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor: decodes each frame against the next expected item
  task automatic decode_frame();
    item_t      it;
    int         nb, np, ns, total;
    logic       e, s1, s2;
    logic [7:0] md;
    string      tag;
    if (q.size() == 0) begin
      chk(1'b0, "R1", "frame with no byte queued", 1, 0);
      while (busy) @(negedge clk);
      return;
    end
    it = q.pop_front();
    nb = 5 + int'(it.l[6:5]);
    np = it.l[1] ? 1 : 0;
    ns = it.l[3] ? 2 : 1;
    total = 1 + nb + np + ns;
    md = 8'h00;
    for (int i = 0; i < nb; i++) md[i] = it.d[i];
    for (int i = 0; i < total; i++) begin
      if (i == 0) begin
        e = 1'b0; tag = "R1";
      end else if (i <= nb) begin
        e = it.d[i-1]; tag = "R1";
      end else if (np == 1 && i == nb + 1) begin
        if (it.l[7]) begin e = ~it.l[2]; tag = "R4"; end
        else begin e = it.l[2] ? ^md : ~^md; tag = "R3"; end
      end else begin
        e = 1'b1; tag = "R5";
      end
      wait_ticks(8);
      s1 = tx;
      wait_ticks(8);
      s2 = tx;
      chk(s1 == e, tag, $sformatf("byte %02h lcr %02h bit %0d mid", it.d, it.l, i), s1, e);
      chk(s2 == e, "R2", $sformatf("byte %02h bit %0d last tick", it.d, i), s2, e);
    end
    @(negedge clk);
    chk(!busy && tx, "R6", $sformatf("idle after byte %02h", it.d), {busy, tx}, 1);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (mon_on && rst_n && !tx) decode_frame();
    end
  end

  task automatic run_all();
    int n, errs0;
    repeat (4) @(negedge clk);
    chk(tx && !busy && empty && ready, "R6", "reset state",
        {tx, busy, empty, ready}, 4'b1011);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx && !busy && empty && ready, "R7", "after reset",
        {tx, busy, empty, ready}, 4'b1011);
    mon_on = 1'b1;

    // R1: 8 data bits, no parity, back to back
    lcr = 8'h60;
    send(8'hA5, 1);
    while (!busy) @(negedge clk);
    chk(empty && ready, "R7", "empty again once frame starts", empty, 1);
    send(8'h3C, 1);
    wait_idle();

    // R3/R5: 5 bits, even parity, two stops
    lcr = 8'h0E;
    send(8'h1F, 1);
    send(8'hE2, 1);
    wait_idle();

    // R3: 6 bits, odd parity
    lcr = 8'h22;
    send(8'h15, 1);
    send(8'h3F, 1);
    wait_idle();

    // R4: sticky, even select -> 0; 7 bits
    lcr = 8'hC6;
    send(8'h7F, 1);
    wait_idle();
    // R4: sticky, even select clear -> 1; 8 bits, two stops
    lcr = 8'hEA;
    send(8'h00, 1);
    wait_idle();

    // R11: queue-enable bit set, plain 8-bit frame expected
    errs0 = errors;
    lcr = 8'h70;
    send(8'h96, 1);
    wait_idle();
    chk(errors == errs0, "R11", "bit 4 left frame unchanged", errors - errs0, 0);

    // R9: settings change mid-frame
    errs0 = errors;
    lcr = 8'h60;
    send(8'h5A, 1);
    while (!busy) @(negedge clk);
    wait_ticks(20);
    lcr = 8'h0E;
    wait_idle();
    chk(errors == errs0, "R9", "frame kept start-time settings", errors - errs0, 0);
    lcr = 8'h60;

    // R8: enable gating
    en = 1'b0;
    send(8'h81, 1);
    wait_ticks(40);
    chk(!busy && tx && !empty, "R8", "held while en_i low", {busy, tx, empty}, 3'b010);
    en = 1'b1; tx_en = 1'b0;
    wait_ticks(40);
    chk(!busy && tx && !empty, "R8", "held while tx_en_i low", {busy, tx, empty}, 3'b010);
    tx_en = 1'b1;
    wait_idle();

    // R10: break mid-frame
    mon_on = 1'b0;
    send(8'hF0, 0);
    while (!busy) @(negedge clk);
    wait_ticks(5);
    lcr = 8'h61;
    @(negedge clk);
    chk(!tx && busy, "R10", "line low on break", {tx, busy}, 2'b01);
    send(8'h33, 1);
    wait_ticks(40);
    chk(!tx && busy && !empty, "R10", "break holds line, byte stays held",
        {tx, busy, empty}, 3'b010);
    @(negedge clk);
    lcr = 8'h60;
    n = tick ? 1 : 0;
    @(negedge clk);
    chk(tx, "R10", "line high after break release", tx, 1);
    mon_on = 1'b1;
    while (tx) begin
      if (tick) n++;
      @(negedge clk);
    end
    chk(n == 17, "R10", "ticks from release to next start bit", n, 17);
    wait_idle();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R6 watchdog expired: actual=%0d expected=%0d", 1, 0);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule